// File: doc/BRIEF.md
# Receive Character Queue with Error Tags

This block sits between a serial receive engine and a host. Each character arrives as a write strobe that carries an 8-bit byte and three error-tag bits. The block keeps the byte and its tags together as one 11-bit entry. The host sees the oldest unread entry on a holding-register output. Each host read strobe retires that entry, and the byte and tags of the next entry appear on the following cycle.

The block has two modes. In queue mode it holds up to 64 entries. It raises a receive interrupt once the fill level reaches one of four selectable thresholds. It also raises a stall-timeout interrupt when characters are left in the queue and no traffic has occurred for four character frames plus twelve bit periods. The frame length follows the programmed word length. In single-register mode the block holds only one character and interrupts on every character. A sticky overrun flag records characters that were dropped because there was no room. An interrupt-enable input gates both interrupts.

Top module: `rxq_tagged_fifo`

## Requirements
- R1: In queue mode up to 64 entries are stored. `fill_count` reports the number stored. Entries leave in the order they were written, each with its own 3 tag bits.
- R2: `head_data`/`head_tags` show the oldest stored entry. A `pop` while `data_ready` is high retires it, and the next entry's byte and tags appear in the following cycle.
- R3: A `push` when the store is already at capacity is dropped, even if a `pop` occurs in the same cycle. The dropped push sets `overrun`. `overrun` stays set until a `status_rd` cycle with no new drop in that cycle.
- R4: With `fifo_en` low the capacity is one entry, so a second `push` before a `pop` is dropped.
- R5: `data_ready` is high exactly when `fill_count` is nonzero.
- R6: In queue mode `rx_irq` is high when `fill_count` is at least the level picked by `trig_sel`: 0→1, 1→8, 2→16, 3→56. In single-register mode `rx_irq` is high whenever an entry is held.
- R7: In queue mode, with data held, `tout_irq` rises after L `bit_tick` cycles with no accepted push or pop. L = 4×(`word_sel`+5+2)+12, which gives 40 for `word_sel`=0 and 52 for `word_sel`=3. It never rises in single-register mode.
- R8: An accepted push restarts the timeout count. An accepted pop clears `tout_irq`, and `tout_irq` is low whenever the store is empty.
- R9: With `irq_en` low, `rx_irq` and `tout_irq` are both low.
- R10: A change of `fifo_en` discards all stored entries. `fill_count` reads 0 two cycles later.
- R11: A `pop` while the store is empty is ignored and leaves `fill_count` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push | input | 1 | Character write strobe from the receive engine |
| push_data | input | 8 | Received byte |
| push_tags | input | 3 | Error tags of the received byte |
| pop | input | 1 | Host read strobe, retires the head entry |
| fifo_en | input | 1 | 1 = 64-entry queue, 0 = single holding register |
| trig_sel | input | 2 | Fill threshold select for `rx_irq` |
| irq_en | input | 1 | Interrupt enable |
| word_sel | input | 2 | Word length is 5 + this value bits |
| bit_tick | input | 1 | One pulse per serial bit period |
| status_rd | input | 1 | Host status read, clears `overrun` |
| head_data | output | 8 | Byte of the oldest entry |
| head_tags | output | 3 | Tags of the oldest entry |
| data_ready | output | 1 | At least one entry is held |
| fill_count | output | 7 | Number of entries held |
| rx_irq | output | 1 | Receive-data interrupt |
| tout_irq | output | 1 | Stall-timeout interrupt |
| overrun | output | 1 | Sticky dropped-character flag |

## Verification
The properties assume that the inputs have known values from the first clock after reset. The mode-dependent properties compare `fifo_en` with the registered mode, so they only apply once a mode change has settled. The stimulus therefore changes `fifo_en` only between transfers and then idles for two cycles before pushing again. Strobes are applied for exactly one cycle each and ticks are spaced apart, so every push, pop and tick lines up with a single edge, as the timeout count assumes.

// File: rtl/rxq_pkg.sv
// Shared types and helpers for the tagged receive queue.
// Assumes an 8-bit data byte and a 3-bit error tag per character.
package rxq_pkg;
    localparam int DATA_W = 8;
    localparam int TAG_W  = 3;

    typedef struct packed {
        logic [TAG_W-1:0]  tags;
        logic [DATA_W-1:0] data;
    } rxq_entry_t;

    // Fill threshold chosen by the 2-bit select field.
    function automatic int unsigned trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 8;
            2'd2:    return 16;
            default: return 56;
        endcase
    endfunction
endpackage

// File: rtl/rxq_store.sv
// Entry storage, pointers, fill count and overrun flag.
// Assumes DEPTH is a power of two so the pointers wrap naturally.
// Capacity is DEPTH in queue mode and 1 in single-register mode. A flush
// empties the store and blocks both strobes in that cycle.
module rxq_store #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                fifo_mode,
    input  logic                wr_req,
    input  rxq_pkg::rxq_entry_t wr_entry,
    input  logic                rd_req,
    input  logic                status_rd,
    output rxq_pkg::rxq_entry_t head,
    output logic [CW-1:0]       count,
    output logic                wr_ok,
    output logic                rd_ok,
    output logic                ovr_flag
);
    localparam logic [CW-1:0] FULL_Q = CW'(DEPTH);
    localparam logic [CW-1:0] ONE_Q  = CW'(1);

    rxq_pkg::rxq_entry_t mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cap;
    logic          drop;

    // Accept/drop decisions for this cycle.
    always_comb begin
        cap   = fifo_mode ? FULL_Q : ONE_Q;
        wr_ok = wr_req && !flush && (count < cap);
        drop  = wr_req && !flush && (count >= cap);
        rd_ok = rd_req && !flush && (count != '0);
    end

    // Storage array write port; no reset needed on the data.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wr_entry;
    end

    // Pointer and fill-count bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_ok) wr_ptr <= wr_ptr + AW'(1);
            if (rd_ok) rd_ptr <= rd_ptr + AW'(1);
            count <= count + CW'(wr_ok) - CW'(rd_ok);
        end
    end

    // Sticky overrun: a drop sets it, a status read clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)         ovr_flag <= 1'b0;
        else if (drop)      ovr_flag <= 1'b1;
        else if (status_rd) ovr_flag <= 1'b0;
    end

    assign head = mem[rd_ptr];
endmodule

// File: rtl/rxq_rx_irq.sv
// Receive-data interrupt: compares the fill level with the selected
// threshold in queue mode, or fires on any held entry otherwise.
// Assumes count is the registered fill level of the store.
module rxq_rx_irq #(
    parameter int CW = 7
) (
    input  logic [CW-1:0] count,
    input  logic          fifo_mode,
    input  logic [1:0]    trig_sel,
    input  logic          irq_en,
    output logic          rx_irq
);
    logic [CW-1:0] level;

    // Threshold decode and comparison.
    always_comb begin
        level  = CW'(rxq_pkg::trig_level(trig_sel));
        rx_irq = irq_en && (fifo_mode ? (count >= level) : (count != '0));
    end
endmodule

// File: rtl/rxq_stall_timer.sv
// Stall timeout: counts bit ticks while the queue holds data without traffic.
// The limit is 4 frames (word + start + stop bits) plus 12 bit times.
// Assumes TW is wide enough for the largest limit (52 fits in 6 bits).
module rxq_stall_timer #(
    parameter int TW = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       restart,
    input  logic       host_rd,
    input  logic       flush,
    input  logic       bit_tick,
    input  logic [1:0] word_sel,
    output logic       pending
);
    logic [TW-1:0] cnt, limit;

    // Frame-length dependent limit.
    always_comb limit = ((TW'(word_sel) + TW'(7)) << 2) + TW'(12);

    // Saturating tick counter, restarted by traffic or inactivity.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || flush || !active) cnt <= '0;
        else if (bit_tick && cnt != limit)          cnt <= cnt + TW'(1);
    end

    // Pending flag: set on reaching the limit, cleared by a read or an empty store.
    always_ff @(posedge clk) begin
        if (!rst_n || host_rd || flush || !active)
            pending <= 1'b0;
        else if (!restart && bit_tick && (cnt + TW'(1) == limit))
            pending <= 1'b1;
    end
endmodule

// File: rtl/rxq_tagged_fifo.sv
// Receive queue top: stores bytes with their error tags, presents the head
// entry to the host and raises the receive and stall-timeout interrupts.
// Assumes strobes last one cycle per character and fifo_en changes rarely;
// a change of fifo_en flushes the store on the following edge.
module rxq_tagged_fifo #(
    parameter int DEPTH = 64,
    parameter int TW    = 6,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [rxq_pkg::DATA_W-1:0] push_data,
    input  logic [rxq_pkg::TAG_W-1:0]  push_tags,
    input  logic                       pop,
    input  logic                       fifo_en,
    input  logic [1:0]                 trig_sel,
    input  logic                       irq_en,
    input  logic [1:0]                 word_sel,
    input  logic                       bit_tick,
    input  logic                       status_rd,
    output logic [rxq_pkg::DATA_W-1:0] head_data,
    output logic [rxq_pkg::TAG_W-1:0]  head_tags,
    output logic                       data_ready,
    output logic [CW-1:0]              fill_count,
    output logic                       rx_irq,
    output logic                       tout_irq,
    output logic                       overrun
);
    rxq_pkg::rxq_entry_t wr_entry, head;
    logic mode_q, flush, wr_ok, rd_ok, tmo_pending, tmo_active;

    // Registered mode; any difference from the input is a pending flush.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= fifo_en;
    end

    // Glue: pack the incoming entry and derive the flush/activity terms.
    always_comb begin
        flush         = (fifo_en != mode_q);
        wr_entry.data = push_data;
        wr_entry.tags = push_tags;
        tmo_active    = mode_q && (fill_count != '0);
    end

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush), .fifo_mode(mode_q),
        .wr_req(push), .wr_entry(wr_entry), .rd_req(pop), .status_rd(status_rd),
        .head(head), .count(fill_count), .wr_ok(wr_ok), .rd_ok(rd_ok),
        .ovr_flag(overrun)
    );

    rxq_rx_irq #(.CW(CW)) u_rx_irq (
        .count(fill_count), .fifo_mode(mode_q), .trig_sel(trig_sel),
        .irq_en(irq_en), .rx_irq(rx_irq)
    );

    rxq_stall_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .active(tmo_active), .restart(wr_ok | rd_ok),
        .host_rd(rd_ok), .flush(flush), .bit_tick(bit_tick),
        .word_sel(word_sel), .pending(tmo_pending)
    );

    // Host-facing outputs.
    always_comb begin
        head_data  = head.data;
        head_tags  = head.tags;
        data_ready = (fill_count != '0);
        tout_irq   = irq_en && tmo_pending;
    end
endmodule

// File: rtl/rxq_tagged_fifo_chk.sv
// Property checker for the receive queue, attached through bind.
// Assumes inputs are known from the first clock after reset.
module rxq_tagged_fifo_chk #(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push,
    input logic          pop,
    input logic          fifo_en,
    input logic          mode_q,
    input logic          irq_en,
    input logic          data_ready,
    input logic [CW-1:0] fill_count,
    input logic          rx_irq,
    input logic          tout_irq,
    input logic          overrun
);
    logic [CW-1:0] cap;
    logic          settled;
    always_comb begin
        cap     = mode_q ? CW'(DEPTH) : CW'(1);
        settled = (mode_q == fifo_en);
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CW'(DEPTH)); // R1
    AST_READ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && data_ready && !push && settled) |=> (fill_count == $past(fill_count) - CW'(1))); // R2
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && settled && fill_count == cap) |=> $stable(fill_count)); // R3
    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (push && settled && fill_count == cap) |=> overrun); // R3
    AST_SINGLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> (fill_count <= CW'(1))); // R4
    AST_NO_TOUT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> !tout_irq); // R7
    AST_EMPTY_NO_TOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == '0) |-> !tout_irq); // R8
    AST_READ_CLEARS_TOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && data_ready && settled) |=> !tout_irq); // R8
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> (!rx_irq && !tout_irq)); // R9
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && fill_count == '0) |=> (fill_count == '0)); // R11
endmodule

bind rxq_tagged_fifo rxq_tagged_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .fifo_en(fifo_en),
    .mode_q(mode_q), .irq_en(irq_en), .data_ready(data_ready),
    .fill_count(fill_count), .rx_irq(rx_irq), .tout_irq(tout_irq),
    .overrun(overrun)
);

// File: tb/rxq_tagged_fifo_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the push task queues expected entries, the monitor
// pops and compares them whenever the host read strobe retires an entry.
module rxq_tagged_fifo_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push = 1'b0, pop = 1'b0, fifo_en = 1'b1, irq_en = 1'b0;
    logic       bit_tick = 1'b0, status_rd = 1'b0;
    logic [7:0] push_data = '0;
    logic [2:0] push_tags = '0;
    logic [1:0] trig_sel = '0, word_sel = '0;
    logic [7:0] head_data;
    logic [2:0] head_tags;
    logic       data_ready, rx_irq, tout_irq, overrun;
    logic [6:0] fill_count;

    int n_checks = 0, n_fail = 0;
    bit finished = 1'b0;
    logic [10:0] sb_q[$];
    int mdl_cnt = 0;

    always #2 clk = ~clk;

    rxq_tagged_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .push_tags(push_tags), .pop(pop), .fifo_en(fifo_en), .trig_sel(trig_sel),
        .irq_en(irq_en), .word_sel(word_sel), .bit_tick(bit_tick),
        .status_rd(status_rd), .head_data(head_data), .head_tags(head_tags),
        .data_ready(data_ready), .fill_count(fill_count), .rx_irq(rx_irq),
        .tout_irq(tout_irq), .overrun(overrun)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: push one character and record it if the model has room.
    task automatic do_push(input logic [7:0] d, input logic [2:0] t);
        int cap;
        cap = fifo_en ? 64 : 1;
        @(posedge clk); #1;
        push = 1'b1; push_data = d; push_tags = t;
        @(posedge clk); #1;
        push = 1'b0;
        if (mdl_cnt < cap) begin
            sb_q.push_back({t, d});
            mdl_cnt++;
        end
    endtask

    task automatic do_pop();
        @(posedge clk); #1; pop = 1'b1;
        @(posedge clk); #1; pop = 1'b0;
        if (mdl_cnt > 0) mdl_cnt--;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1; bit_tick = 1'b1;
            @(posedge clk); #1; bit_tick = 1'b0;
        end
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    // Monitor: compare the head entry against the scoreboard on each retire.
    always @(negedge clk) begin
        if (pop && data_ready) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R2 unexpected entry", {head_tags, head_data}, 0);
            end else begin
                logic [10:0] exp_e;
                exp_e = sb_q.pop_front();
                check({head_tags, head_data} == exp_e, "R1/R2 head entry",
                      {head_tags, head_data}, exp_e);
            end
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        settle();
        check(fill_count == 0 && !data_ready && !rx_irq && !tout_irq && !overrun,
              "reset state", {fill_count, data_ready, rx_irq, tout_irq, overrun}, 0);

        // R6 threshold 8, R5 ready flag
        irq_en = 1'b1; trig_sel = 2'd1; word_sel = 2'd0;
        for (int i = 0; i < 7; i++) do_push(8'h10 + 8'(i), 3'(i));
        settle();
        check(!rx_irq, "R6 below level 8", rx_irq, 0);
        check(data_ready, "R5 ready when nonempty", data_ready, 1);
        do_push(8'h17, 3'd7);
        settle();
        check(rx_irq, "R6 at level 8", rx_irq, 1);

        // R7 timeout at 40 ticks for word_sel 0
        ticks(39); settle();
        check(!tout_irq, "R7 before limit 40", tout_irq, 0);
        ticks(1); settle();
        check(tout_irq, "R7 at limit 40", tout_irq, 1);

        // R9 gating
        irq_en = 1'b0; settle();
        check(!rx_irq && !tout_irq, "R9 gated", {rx_irq, tout_irq}, 0);
        irq_en = 1'b1;

        // R8 read clears timeout
        do_pop(); settle();
        check(!tout_irq, "R8 read clears timeout", tout_irq, 0);
        while (mdl_cnt > 0) do_pop();
        settle();
        check(fill_count == 0, "R1 drained", fill_count, 0);

        // R8 push restarts the timeout count
        do_push(8'hA1, 3'd1);
        ticks(30);
        do_push(8'hA2, 3'd2);
        ticks(30); settle();
        check(!tout_irq, "R8 restart on push", tout_irq, 0);
        ticks(10); settle();
        check(tout_irq, "R8 limit after restart", tout_irq, 1);
        do_pop(); do_pop();

        // R7 word_sel 3 gives limit 52
        word_sel = 2'd3;
        do_push(8'hB3, 3'd3);
        ticks(51); settle();
        check(!tout_irq, "R7 before limit 52", tout_irq, 0);
        ticks(1); settle();
        check(tout_irq, "R7 at limit 52", tout_irq, 1);
        do_pop(); settle();
        check(!tout_irq && fill_count == 0, "R8 empty no timeout", tout_irq, 0);

        // R6 thresholds 16 and 56, R1 full depth, R3 overrun
        trig_sel = 2'd2;
        for (int i = 0; i < 15; i++) do_push(8'(i * 3), 3'(i));
        settle();
        check(!rx_irq, "R6 below level 16", rx_irq, 0);
        do_push(8'hC0, 3'd5); settle();
        check(rx_irq, "R6 at level 16", rx_irq, 1);
        trig_sel = 2'd3; settle();
        check(!rx_irq, "R6 level 56 not reached", rx_irq, 0);
        trig_sel = 2'd0; settle();
        check(rx_irq, "R6 level 1", rx_irq, 1);
        trig_sel = 2'd3;
        for (int i = 16; i < 55; i++) do_push(8'(i * 5), 3'(i));
        settle();
        check(!rx_irq, "R6 count 55 below 56", rx_irq, 0);
        do_push(8'hD7, 3'd6); settle();
        check(rx_irq, "R6 at level 56", rx_irq, 1);
        for (int i = 56; i < 64; i++) do_push(8'(i), 3'(i + 1));
        settle();
        check(fill_count == 64 && !overrun, "R1 full at 64", fill_count, 64);
        do_push(8'hEE, 3'd7); settle();
        check(fill_count == 64, "R3 drop keeps count", fill_count, 64);
        check(overrun, "R3 overrun set", overrun, 1);
        @(posedge clk); #1 status_rd = 1'b1;
        @(posedge clk); #1 status_rd = 1'b0;
        settle();
        check(!overrun, "R3 overrun cleared", overrun, 0);
        while (mdl_cnt > 0) do_pop();
        settle();
        check(sb_q.size() == 0 && fill_count == 0, "R1 all entries out", fill_count, 0);

        // R11 empty read ignored
        do_pop(); settle();
        check(fill_count == 0 && !data_ready, "R11 empty pop ignored", fill_count, 0);

        // R10 mode change flushes
        do_push(8'h51, 3'd1); do_push(8'h52, 3'd2); do_push(8'h53, 3'd3);
        @(posedge clk); #1 fifo_en = 1'b0;
        repeat (2) @(posedge clk);
        settle();
        check(fill_count == 0 && !data_ready, "R10 flush on mode change", fill_count, 0);
        sb_q.delete(); mdl_cnt = 0;

        // R4 single holding register, R6 per-character interrupt
        do_push(8'h61, 3'd4); settle();
        check(rx_irq, "R6 single mode per char", rx_irq, 1);
        do_push(8'h62, 3'd5); settle();
        check(fill_count == 1 && overrun, "R4 second push dropped", fill_count, 1);
        ticks(60); settle();
        check(!tout_irq, "R7 no timeout single mode", tout_irq, 0);
        do_pop(); settle();
        check(fill_count == 0, "R4 emptied", fill_count, 0);
        do_push(8'h63, 3'd6); do_pop(); settle();
        check(sb_q.size() == 0, "R2 scoreboard empty", sb_q.size(), 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule